// File: doc/BRIEF.md
# Three-Digit Combination Lock Controller

This block is a clocked lock that takes a secret code of three fixed digits and checks a user's entry one digit at a time. The user places a digit on the digit input and pulses the enter strobe for one clock. A small controller walks through three compare states. Each state picks the expected code digit through a one-hot multiplexer and feeds it to an equality comparator. The controller then moves to the next compare state, to the open state, or to the error state.

The states are encoded so that the outputs need no decode logic. The low three state bits are the multiplexer select and the top bit is the door-open level. The error state is the all-zero code. The open and error states are terminal: they stay put until reset. The code digits are elaboration-time parameters, and all inputs are treated as synchronous to the clock.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the lock enters the first compare state. `door_open` is then 0 and `dig_sel` is 3'b001, which selects the first code digit.
- R2: In a compare state, a rising edge with `enter` high and `digit_in` equal to the selected code digit advances the select. It moves from 3'b001 to 3'b010, and from 3'b010 to 3'b100.
- R3: In the third compare state (`dig_sel` = 3'b100), a matching entry moves the lock to the open state. There `door_open` is 1 and `dig_sel` is 3'b000.
- R4: In any compare state, an entry with `enter` high and a mismatching digit moves the lock to the error state. There `door_open` is 0 and `dig_sel` is 3'b000.
- R5: In a compare state, a rising edge with `enter` low leaves `door_open` and `dig_sel` unchanged, whatever `digit_in` is.
- R6: The open and error states ignore `enter` and `digit_in` and hold until `rst` is asserted.
- R7: `rst` takes priority over `enter` in the same cycle, even when the digit presented would match.
- R8: `enter` is sampled on every edge. If it is held high for N cycles, it counts as N separate entries of the digit presented.
- R9: `dig_sel` is never more than one-hot. `door_open` is 1 only while `dig_sel` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, highest priority |
| digit_in | input | DIGIT_W | Digit currently presented by the user |
| enter | input | 1 | Entry strobe, one cycle per digit |
| door_open | output | 1 | 1 when the lock is open (top state bit) |
| dig_sel | output | 3 | One-hot code digit select (low state bits) |

## Verification
The outputs are raw state bits, so any wrong state shows at the ports in the cycle after the edge that produced it. A missed advance shows as a stale select. A false mismatch shows as a zero select with the door closed. A corrupt encoding shows as a select with more than one bit set. Errors that look alike at the ports, such as an error state that leaks back into a compare state, show up as soon as one more edge passes with a strobe. The bench applies such strobes in both terminal states.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int STATE_W = 4;
    localparam int SEL_W   = 3;

    // Outputs are raw state bits: [3] = open, [2:0] = digit select.
    typedef enum logic [STATE_W-1:0] {
        ST_ERR  = 4'b0000,
        ST_D1   = 4'b0001,
        ST_D2   = 4'b0010,
        ST_D3   = 4'b0100,
        ST_OPEN = 4'b1000
    } lock_state_e;

    typedef struct packed {
        logic             opened;
        logic [SEL_W-1:0] sel;
    } lock_out_t;

    function automatic lock_out_t state_to_out(input lock_state_e s);
        lock_out_t o;
        o.opened = s[STATE_W-1];
        o.sel    = s[SEL_W-1:0];
        return o;
    endfunction

    function automatic lock_state_e advance(input lock_state_e s);
        case (s)
            ST_D1:   return ST_D2;
            ST_D2:   return ST_D3;
            ST_D3:   return ST_OPEN;
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/digit_mux.sv
module digit_mux #(
    parameter int DW  = 4,
    parameter int NUM = 3
) (
    input  logic [NUM*DW-1:0] digits,
    input  logic [NUM-1:0]    sel,
    output logic [DW-1:0]     q
);
    // Per output bit: AND each candidate with its select line, then OR them.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic [NUM-1:0] col;
        for (genvar k = 0; k < NUM; k++) begin : g_src
            assign col[k] = digits[k*DW + b] & sel[k];
        end
        assign q[b] = |col;
    end
endmodule

// File: rtl/digit_cmp.sv
module digit_cmp #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          eq
);
    logic [DW-1:0] same;
    for (genvar i = 0; i < DW; i++) begin : g_xnor
        assign same[i] = ~(a[i] ^ b[i]);
    end
    assign eq = &same;
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enter,
    input  logic        eq,
    output lock_state_e state
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_D1, ST_D2, ST_D3: begin
                if (enter) state_d = eq ? advance(state_q) : ST_ERR;
            end
            ST_OPEN: state_d = ST_OPEN;
            ST_ERR:  state_d = ST_ERR;
            default: state_d = ST_ERR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_D1;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
#(
    parameter int                 DIGIT_W = 4,
    parameter logic [DIGIT_W-1:0] CODE_1  = 4'h5,
    parameter logic [DIGIT_W-1:0] CODE_2  = 4'h5,
    parameter logic [DIGIT_W-1:0] CODE_3  = 4'hA
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] digit_in,
    input  logic               enter,
    output logic               door_open,
    output logic [SEL_W-1:0]   dig_sel
);
    localparam logic [SEL_W*DIGIT_W-1:0] CODE_BUS = {CODE_3, CODE_2, CODE_1};

    lock_state_e        state;
    lock_out_t          outs;
    logic [DIGIT_W-1:0] expected;
    logic               match;

    assign outs      = state_to_out(state);
    assign door_open = outs.opened;
    assign dig_sel   = outs.sel;

    digit_mux #(.DW(DIGIT_W), .NUM(SEL_W)) u_mux (
        .digits (CODE_BUS),
        .sel    (outs.sel),
        .q      (expected)
    );

    digit_cmp #(.DW(DIGIT_W)) u_cmp (
        .a  (digit_in),
        .b  (expected),
        .eq (match)
    );

    lock_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .enter (enter),
        .eq    (match),
        .state (state)
    );
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
    parameter int               DW = 4,
    parameter logic [DW-1:0]    K1 = 4'h5,
    parameter logic [DW-1:0]    K2 = 4'h5,
    parameter logic [DW-1:0]    K3 = 4'hA
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] digit_in,
    input logic          enter,
    input logic          door_open,
    input logic [2:0]    dig_sel
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dig_sel == 3'b001 && !door_open));

    assert_advance_first_R2: assert property (@(posedge clk) disable iff (rst)
        (enter && dig_sel == 3'b001 && digit_in == K1) |=> dig_sel == 3'b010);

    assert_advance_second_R2: assert property (@(posedge clk) disable iff (rst)
        (enter && dig_sel == 3'b010 && digit_in == K2) |=> dig_sel == 3'b100);

    assert_open_on_last_R3: assert property (@(posedge clk) disable iff (rst)
        (enter && dig_sel == 3'b100 && digit_in == K3) |=> (door_open && dig_sel == 3'b000));

    assert_mismatch_err_R4: assert property (@(posedge clk) disable iff (rst)
        (enter && dig_sel == 3'b001 && digit_in != K1) |=> (!door_open && dig_sel == 3'b000));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!enter && dig_sel != 3'b000) |=> ($stable(dig_sel) && $stable(door_open)));

    assert_open_holds_R6: assert property (@(posedge clk) disable iff (rst)
        door_open |=> door_open);

    assert_err_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!door_open && dig_sel == 3'b000) |=> (!door_open && dig_sel == 3'b000));

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_sel));

    assert_open_no_sel_R9: assert property (@(posedge clk) disable iff (rst)
        door_open |-> dig_sel == 3'b000);
endmodule

bind combo_lock lock_chk #(.DW(DIGIT_W), .K1(CODE_1), .K2(CODE_2), .K3(CODE_3)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .digit_in  (digit_in),
    .enter     (enter),
    .door_open (door_open),
    .dig_sel   (dig_sel)
);

// File: tb/sim_combo_lock.sv
module sim_combo_lock;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] K1 = 4'h5, K2 = 4'h5, K3 = 4'hA;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] digit_in = 4'h0;
    logic       enter = 1'b0;
    logic       door_open;
    logic [2:0] dig_sel;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    combo_lock #(.DIGIT_W(4), .CODE_1(K1), .CODE_2(K2), .CODE_3(K3)) u0 (
        .clk(clk), .rst(rst), .digit_in(digit_in), .enter(enter),
        .door_open(door_open), .dig_sel(dig_sel)
    );

    task automatic check(input string req, input logic exp_open, input logic [2:0] exp_sel);
        n_checks++;
        if (door_open !== exp_open || dig_sel !== exp_sel) begin
            n_errors++;
            $display("FAIL %s: got open=%b sel=%b, expected open=%b sel=%b",
                     req, door_open, dig_sel, exp_open, exp_sel);
        end
    endtask

    // One edge with the given inputs; returns at the following falling edge.
    task automatic step(input logic r, input logic e, input logic [3:0] d);
        rst = r; enter = e; digit_in = d;
        @(negedge clk);
        rst = 1'b0; enter = 1'b0;
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 4'h0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", 1'b0, 3'b001);
    endtask

    task automatic t_correct_sequence();
        do_reset();
        step(1'b0, 1'b1, K1); check("R2 first digit advances", 1'b0, 3'b010);
        step(1'b0, 1'b1, K2); check("R2 second digit advances", 1'b0, 3'b100);
        step(1'b0, 1'b1, K3); check("R3 third digit opens", 1'b1, 3'b000);
    endtask

    task automatic t_wrong_at(input int pos);
        do_reset();
        if (pos > 0) step(1'b0, 1'b1, K1);
        if (pos > 1) step(1'b0, 1'b1, K2);
        step(1'b0, 1'b1, (pos == 2) ? ~K3 : 4'h3);
        check($sformatf("R4 mismatch at digit %0d", pos + 1), 1'b0, 3'b000);
    endtask

    task automatic t_idle_hold();
        do_reset();
        step(1'b0, 1'b0, K1); check("R5 no strobe holds first", 1'b0, 3'b001);
        step(1'b0, 1'b1, K1);
        step(1'b0, 1'b0, 4'h3); check("R5 no strobe wrong digit holds", 1'b0, 3'b010);
        step(1'b0, 1'b0, K2); check("R5 no strobe right digit holds", 1'b0, 3'b010);
    endtask

    task automatic t_terminal_ignore();
        t_correct_sequence();
        step(1'b0, 1'b1, K1); check("R6 open ignores strobe", 1'b1, 3'b000);
        step(1'b0, 1'b1, 4'hF); check("R6 open ignores wrong strobe", 1'b1, 3'b000);
        do_reset(); check("R6 open leaves on reset", 1'b0, 3'b001);
        step(1'b0, 1'b1, 4'h0);
        step(1'b0, 1'b1, K1); check("R6 error ignores code digit", 1'b0, 3'b000);
        step(1'b0, 1'b1, K2);
        step(1'b0, 1'b1, K3); check("R6 error ignores full code", 1'b0, 3'b000);
        do_reset(); check("R6 error leaves on reset", 1'b0, 3'b001);
    endtask

    task automatic t_reset_priority();
        do_reset();
        step(1'b0, 1'b1, K1);
        step(1'b1, 1'b1, K2); check("R7 reset beats matching entry", 1'b0, 3'b001);
        step(1'b0, 1'b1, K1); step(1'b0, 1'b1, K2);
        step(1'b1, 1'b1, K3); check("R7 reset beats opening entry", 1'b0, 3'b001);
    endtask

    task automatic t_held_strobe();
        do_reset();
        rst = 1'b0; enter = 1'b1; digit_in = K1;
        @(negedge clk); @(negedge clk);
        check("R8 two-cycle strobe counts twice", 1'b0, 3'b100);
        @(negedge clk);
        enter = 1'b0;
        check("R8 third held cycle is a mismatch", 1'b0, 3'b000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_correct_sequence();
        for (int p = 0; p < 3; p++) t_wrong_at(p);
        t_idle_hold();
        t_terminal_ignore();
        t_reset_priority();
        t_held_strobe();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule